// File: doc/BRIEF.md
# Shadowed Output Compare Channel

This block is a single output compare channel for a capture/compare timer. The timer count and its overflow strobe come from outside. The channel holds a compare value, and when the count equals that value it drives a pin latch and sets a sticky interrupt flag. A mode field decides what a match does to the pin: nothing, set it, clear it or toggle it.

Software never writes the active compare value directly. Byte writes go into a shadow register, and an update strobe moves the shadow into the active register. In basic timer mode the move happens at once. In PWM mode it waits for the next timer overflow, and a pending flag stays visible until then. The same strobe also commits a shadowed timer reload (top-of-count) value. A compare value above the reload value is outside the counting range and never causes an action.

A forced compare applies the mode's pin action without a timer match and without raising the interrupt flag. It takes effect only in basic timer mode. In PWM mode the force bit is stored and read back, but it does nothing to the pin.

Top module: `occ_channel`

## Requirements
- R1: After reset the pin is 0, the match flag is 0, the update-pending flag is 0, the active compare value is 0 and the active reload value is all ones.
- R2: Writes to compare or reload bytes (byte lane b is bits 8b+7..8b) change only the shadow registers. Active values stay the same until a commit.
- R3: In basic mode (pwm_mode=0), an update strobe copies both shadows into the active registers on that clock edge, and upd_pending stays 0.
- R4: In PWM mode an update strobe sets upd_pending. The copy happens on the edge where tmr_ovf is high, and upd_pending clears on that same edge. A second strobe while a copy is pending keeps it pending, and the copy uses the shadow contents at overflow time. A strobe in the overflow cycle itself is served by that overflow.
- R5: The reload shadow is committed by the same update strobe and follows the same timing as the compare shadow.
- R6: A match is tmr_cnt equal to the active compare value while that value is not above the active reload value. On the next edge a match sets the flag and applies the stored mode to the pin: 00 hold, 01 set, 10 clear, 11 toggle.
- R7: When the active compare value is above the active reload value, a count equal to it sets no flag and leaves the pin unchanged.
- R8: In basic mode, a control write with ctrl_force=1 applies the action of the mode written in that same write to the pin and leaves the flag unchanged. force_rd reads 0 in basic mode. If a force and a match occur in the same cycle, only the force action is applied.
- R9: In PWM mode a forced write does not change the pin, and force_rd returns the last force bit written.
- R10: irq_clr clears the flag. A match in the same cycle wins, and the flag is then 1.
- R11: The pin holds its value in every cycle that has neither a match nor an effective force.
- R12: A pending request is dropped without a copy if pwm_mode is 0 on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt | input | CW | Running timer count |
| tmr_ovf | input | 1 | One-cycle timer overflow strobe |
| pwm_mode | input | 1 | 1 = PWM mode, 0 = basic timer mode |
| wr_data | input | 8 | Byte data for shadow writes |
| cmp_byte_we | input | CW/8 | Per-byte write enables, compare shadow |
| rld_byte_we | input | CW/8 | Per-byte write enables, reload shadow |
| upd_we | input | 1 | Write of 1 to the update bit |
| ctrl_we | input | 1 | Control write (mode and force bit) |
| ctrl_mode | input | 2 | Mode bits written with ctrl_we |
| ctrl_force | input | 1 | Force bit written with ctrl_we |
| irq_clr | input | 1 | Write of 1 clearing the match flag |
| oc_pin | output | 1 | Output compare latch |
| match_flag | output | 1 | Sticky compare-match interrupt flag |
| upd_pending | output | 1 | Update bit readback (copy pending) |
| force_rd | output | 1 | Force bit readback |
| cmp_active | output | CW | Active compare value |
| rld_active | output | CW | Active reload value |

## Verification
The bench targets a repeated update strobe while a PWM copy is pending. A design that latched too early would show the stale first shadow. It checks that a compare value just above the reload value stays inert; an off-by-one range test would fire there. It checks that a force raises no flag. A design that routed the force through the match path would set the interrupt. It also makes a match coincide with a flag clear, and leaves PWM mode while a copy is pending. A wrong priority clears the flag in the first case. A leaked request commits in the second. A long pseudo-random phase runs against a cycle-level reference model.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [1:0] {
    OC_HOLD = 2'b00,
    OC_SET  = 2'b01,
    OC_CLR  = 2'b10,
    OC_TOG  = 2'b11
  } oc_act_e;

  function automatic logic oc_apply(input oc_act_e act, input logic cur);
    case (act)
      OC_SET:  oc_apply = 1'b1;
      OC_CLR:  oc_apply = 1'b0;
      OC_TOG:  oc_apply = ~cur;
      default: oc_apply = cur;
    endcase
  endfunction

  function automatic logic oc_in_range(input logic [63:0] cmp, input logic [63:0] top);
    oc_in_range = (cmp <= top);
  endfunction

endpackage

// File: rtl/occ_shadow.sv
module occ_shadow #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W/8-1:0] byte_we,
  input  logic [7:0]     din,
  input  logic           commit,
  output logic [W-1:0]   shadow_q,
  output logic [W-1:0]   active_q
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)          shadow_q[b*8 +: 8] <= RST_VAL[b*8 +: 8];
      else if (byte_we[b]) shadow_q[b*8 +: 8] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      active_q <= RST_VAL;
    else if (commit) active_q <= shadow_q;
  end

  // R2: active value moves only on a commit
  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));
  // R3: a commit loads the shadow seen in that cycle
  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active_q == $past(shadow_q));

endmodule

// File: rtl/occ_update_ctl.sv
module occ_update_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_mode,
  input  logic upd_we,
  input  logic tmr_ovf,
  output logic commit,
  output logic pending
);
  logic req_any;

  assign req_any = pending | upd_we;
  assign commit  = pwm_mode ? (tmr_ovf & req_any) : upd_we;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pwm_mode & req_any & ~tmr_ovf;
  end

  // R3: basic mode never leaves a request pending
  p_basic_no_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_mode |=> !pending);
  // R4: overflow in PWM mode serves the request
  p_ovf_serves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && tmr_ovf) |=> !pending);
  // R4: a repeated strobe keeps the request alive
  p_retrigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && pending && !tmr_ovf) |=> pending);

endmodule

// File: rtl/occ_pin.sv
module occ_pin
  import occ_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    force_act,
  input  oc_act_e force_sel,
  input  logic    match,
  input  oc_act_e match_sel,
  input  logic    irq_clr,
  output logic    pin_q,
  output logic    flag_q
);
  logic pin_nxt;

  always_comb begin
    if (force_act)  pin_nxt = oc_apply(force_sel, pin_q);
    else if (match) pin_nxt = oc_apply(match_sel, pin_q);
    else            pin_nxt = pin_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin_nxt;
      flag_q <= match | (flag_q & ~irq_clr);
    end
  end

  // R11: no event, no pin movement
  p_pin_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_act && !match) |=> $stable(pin_q));
  // R8: a force alone raises no interrupt
  p_force_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_act && !match && !flag_q) |=> !flag_q);
  // R10: a match beats a same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);

endmodule

// File: rtl/occ_channel.sv
module occ_channel
  import occ_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   tmr_cnt,
  input  logic            tmr_ovf,
  input  logic            pwm_mode,
  input  logic [7:0]      wr_data,
  input  logic [CW/8-1:0] cmp_byte_we,
  input  logic [CW/8-1:0] rld_byte_we,
  input  logic            upd_we,
  input  logic            ctrl_we,
  input  logic [1:0]      ctrl_mode,
  input  logic            ctrl_force,
  input  logic            irq_clr,
  output logic            oc_pin,
  output logic            match_flag,
  output logic            upd_pending,
  output logic            force_rd,
  output logic [CW-1:0]   cmp_active,
  output logic [CW-1:0]   rld_active
);
  localparam logic [CW-1:0] RLD_RST = '1;

  oc_act_e       mode_q;
  logic          force_q;
  logic          commit;
  logic          cmp_hit;
  logic          force_act;
  logic [CW-1:0] cmp_shadow;
  logic [CW-1:0] rld_shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= OC_HOLD;
      force_q <= 1'b0;
    end else if (ctrl_we) begin
      mode_q  <= oc_act_e'(ctrl_mode);
      force_q <= ctrl_force;
    end
  end

  assign force_rd  = pwm_mode & force_q;
  assign force_act = ctrl_we & ctrl_force & ~pwm_mode;
  assign cmp_hit   = (tmr_cnt == cmp_active) &&
                     oc_in_range(64'(cmp_active), 64'(rld_active));

  occ_update_ctl u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_mode (pwm_mode),
    .upd_we   (upd_we),
    .tmr_ovf  (tmr_ovf),
    .commit   (commit),
    .pending  (upd_pending)
  );

  occ_shadow #(.W(CW), .RST_VAL('0)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_we  (cmp_byte_we),
    .din      (wr_data),
    .commit   (commit),
    .shadow_q (cmp_shadow),
    .active_q (cmp_active)
  );

  occ_shadow #(.W(CW), .RST_VAL(RLD_RST)) u_rld (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_we  (rld_byte_we),
    .din      (wr_data),
    .commit   (commit),
    .shadow_q (rld_shadow),
    .active_q (rld_active)
  );

  occ_pin u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_act (force_act),
    .force_sel (oc_act_e'(ctrl_mode)),
    .match     (cmp_hit),
    .match_sel (mode_q),
    .irq_clr   (irq_clr),
    .pin_q     (oc_pin),
    .flag_q    (match_flag)
  );

  // R7: a count equal to an out-of-range compare value is inert
  p_out_of_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt == cmp_active && cmp_active > rld_active && !force_act && !match_flag)
      |=> !match_flag && $stable(oc_pin));
  // R12: leaving PWM drops a pending request
  p_drop_on_basic_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && !pwm_mode && !upd_we) |=> $stable(cmp_active) && !upd_pending);

endmodule

// File: tb/occ_channel_tb.sv
module occ_channel_tb;
  localparam int CW = 16;
  localparam int NB = CW / 8;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] tmr_cnt = 0;
  logic tmr_ovf = 0, pwm_mode = 0, upd_we = 0, ctrl_we = 0, ctrl_force = 0, irq_clr = 0;
  logic [7:0] wr_data = 0;
  logic [NB-1:0] cmp_byte_we = 0, rld_byte_we = 0;
  logic [1:0] ctrl_mode = 0;
  logic oc_pin, match_flag, upd_pending, force_rd;
  logic [CW-1:0] cmp_active, rld_active;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  occ_channel #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_ovf(tmr_ovf), .pwm_mode(pwm_mode),
    .wr_data(wr_data), .cmp_byte_we(cmp_byte_we), .rld_byte_we(rld_byte_we),
    .upd_we(upd_we), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode), .ctrl_force(ctrl_force),
    .irq_clr(irq_clr), .oc_pin(oc_pin), .match_flag(match_flag), .upd_pending(upd_pending),
    .force_rd(force_rd), .cmp_active(cmp_active), .rld_active(rld_active));

  // reference model, behavioural
  int m_cmp_s, m_cmp_a, m_rld_s, m_rld_a, m_mode;
  bit m_pend, m_pin, m_flag, m_force;

  function automatic bit act(int mode, bit cur);
    if (mode == 1) return 1;
    if (mode == 2) return 0;
    if (mode == 3) return !cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp_s = 0; m_cmp_a = 0; m_rld_s = 65535; m_rld_a = 65535;
      m_mode = 0; m_pend = 0; m_pin = 0; m_flag = 0; m_force = 0;
    end else begin
      bit go, hit, fz;
      int ocs, ors, omode;
      ocs = m_cmp_s; ors = m_rld_s; omode = m_mode;
      hit = (int'(tmr_cnt) == m_cmp_a) && (m_cmp_a <= m_rld_a);
      if (pwm_mode) go = tmr_ovf && (m_pend || upd_we);
      else          go = upd_we;
      m_pend = pwm_mode && (m_pend || upd_we) && !tmr_ovf;
      if (go) begin m_cmp_a = ocs; m_rld_a = ors; end
      for (int b = 0; b < NB; b++) begin
        if (cmp_byte_we[b]) m_cmp_s = (m_cmp_s & ~(255 << (8*b))) | (int'(wr_data) << (8*b));
        if (rld_byte_we[b]) m_rld_s = (m_rld_s & ~(255 << (8*b))) | (int'(wr_data) << (8*b));
      end
      fz = ctrl_we && ctrl_force && !pwm_mode;
      if (fz)       m_pin = act(ctrl_mode, m_pin);
      else if (hit) m_pin = act(omode, m_pin);
      m_flag = hit || (m_flag && !irq_clr);
      if (ctrl_we) begin m_mode = ctrl_mode; m_force = ctrl_force; end
    end
  end

  task automatic chk(input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R6/R11 pin vs model", oc_pin, m_pin);
    chk("R10 flag vs model", match_flag, m_flag);
    chk("R4 pending vs model", upd_pending, m_pend);
    chk("R9 force_rd vs model", force_rd, pwm_mode && m_force);
    chk("R3 cmp_active vs model", cmp_active, m_cmp_a);
    chk("R5 rld_active vs model", rld_active, m_rld_a);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) cmp_model();
    cmp_byte_we = 0; rld_byte_we = 0; upd_we = 0; ctrl_we = 0;
    ctrl_force = 0; irq_clr = 0; tmr_ovf = 0;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    wr_data = v[7:0]; cmp_byte_we = 2'b01; cyc();
    wr_data = v[15:8]; cmp_byte_we = 2'b10; cyc();
  endtask

  task automatic wr_rld(input logic [15:0] v);
    wr_data = v[7:0]; rld_byte_we = 2'b01; cyc();
    wr_data = v[15:8]; rld_byte_we = 2'b10; cyc();
  endtask

  task automatic ctrl(input logic [1:0] m, input logic f);
    ctrl_we = 1; ctrl_mode = m; ctrl_force = f; cyc();
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    tmr_cnt = 16'hFFF0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin", oc_pin, 0);
    chk("R1 flag", match_flag, 0);
    chk("R1 pending", upd_pending, 0);
    chk("R1 cmp_active", cmp_active, 0);
    chk("R1 rld_active", rld_active, 16'hFFFF);

    // R2 / R3 basic-mode commit
    wr_cmp(16'h0012);
    chk("R2 active unchanged", cmp_active, 0);
    upd_we = 1; cyc();
    chk("R3 immediate copy", cmp_active, 16'h0012);
    chk("R3 pending reads 0", upd_pending, 0);

    // R6 set on match, then toggle
    ctrl(2'b01, 0);
    tmr_cnt = 16'h0012; cyc(); tmr_cnt = 16'h0100;
    chk("R6 set on match", oc_pin, 1);
    chk("R6 flag set", match_flag, 1);
    irq_clr = 1; cyc();
    chk("R10 flag cleared", match_flag, 0);
    ctrl(2'b11, 0);
    tmr_cnt = 16'h0012; cyc(); tmr_cnt = 16'h0100;
    chk("R6 toggle", oc_pin, 0);
    repeat (3) cyc();
    chk("R11 pin held", oc_pin, 0);

    // R7 out of range: reload 0x0011 just below compare 0x0012
    irq_clr = 1; cyc();
    wr_rld(16'h0011);
    chk("R2 reload shadow only", rld_active, 16'hFFFF);
    upd_we = 1; cyc();
    chk("R5 reload committed", rld_active, 16'h0011);
    tmr_cnt = 16'h0012; cyc(); tmr_cnt = 16'h0100;
    chk("R7 no flag", match_flag, 0);
    chk("R7 pin unchanged", oc_pin, 0);
    wr_rld(16'hFFFF); upd_we = 1; cyc();

    // R8 force in basic mode
    ctrl(2'b01, 1);
    chk("R8 force sets pin", oc_pin, 1);
    chk("R8 no flag", match_flag, 0);
    chk("R8 force_rd zero", force_rd, 0);
    // R8 force and match together: force action only (clear), once
    ctrl(2'b11, 0);
    ctrl_we = 1; ctrl_mode = 2'b10; ctrl_force = 1; tmr_cnt = 16'h0012; cyc(); tmr_cnt = 16'h0100;
    chk("R8 force wins over match", oc_pin, 0);
    irq_clr = 1; cyc();

    // R4 PWM deferred commit with retrigger
    pwm_mode = 1;
    wr_cmp(16'h0034); upd_we = 1; cyc();
    chk("R4 pending set", upd_pending, 1);
    chk("R4 not yet copied", cmp_active, 16'h0012);
    wr_data = 8'h56; cmp_byte_we = 2'b01; upd_we = 1; cyc();
    repeat (2) cyc();
    chk("R4 still pending", upd_pending, 1);
    tmr_ovf = 1; cyc();
    chk("R4 copied latest shadow", cmp_active, 16'h0056);
    chk("R4 pending cleared", upd_pending, 0);
    // strobe in the overflow cycle
    wr_cmp(16'h0020); upd_we = 1; tmr_ovf = 1; cyc();
    chk("R4 same-cycle overflow", cmp_active, 16'h0020);
    chk("R4 no residue", upd_pending, 0);

    // R9 force ignored in PWM mode
    ctrl(2'b01, 1);
    chk("R9 pin unchanged", oc_pin, 0);
    chk("R9 force reads back", force_rd, 1);

    // R12 leaving PWM drops request
    wr_cmp(16'h0044); upd_we = 1; cyc();
    pwm_mode = 0; cyc();
    chk("R12 pending dropped", upd_pending, 0);
    chk("R12 no copy", cmp_active, 16'h0020);

    // R10 set wins over clear
    ctrl(2'b00, 0);
    tmr_cnt = 16'h0020; irq_clr = 1; cyc(); tmr_cnt = 16'h0100;
    chk("R10 set wins", match_flag, 1);
    chk("R6 mode 00 holds pin", oc_pin, 0);

    // pseudo-random phase with a free-running counter (top 0x3F)
    wr_rld(16'h003F); upd_we = 1; cyc();
    lf = 16'hACE1;
    tmr_cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pwm_mode = (i >= 1500);
      if (lf[1:0] == 2'b00) begin
        cmp_byte_we = lf[2] ? 2'b01 : 2'b10;
        wr_data = lf[2] ? {2'b00, lf[13:8]} : {7'd0, lf[14] & lf[15]};
      end
      if (lf[6:3] == 4'd0) begin ctrl_we = 1; ctrl_mode = lf[8:7]; ctrl_force = lf[9]; end
      if (lf[5:4] == 2'b11) upd_we = 1;
      if (lf[11:10] == 2'b00) irq_clr = 1;
      tmr_ovf = (tmr_cnt == 16'h003F);
      cyc();
      tmr_cnt = (tmr_cnt == 16'h003F) ? 16'd0 : tmr_cnt + 16'd1;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule